// File: doc/BRIEF.md
# Switch CPU-Tag Ingress Parser

This block sits on the port that faces the management processor of an Ethernet switch. Frames arrive one byte per cycle on a valid/ready stream with start-of-frame and end-of-frame markers. The block looks for the switch's management tag right after the two MAC addresses, decodes the tag's control fields and removes the eight tag bytes. The shortened frame then goes downstream together with a sideband of decoded controls. The sideband carries the learning identifier and its enable, the priority and its enable, the keep flag, the learning-disable flag, and the allow flag with an effective egress port mask.

Before it emits anything, the parser collects the first twenty bytes of each frame. This lets the sideband be present on the first output beat. It then replays the buffered header and switches to a straight pass-through for the rest of the frame. A frame whose tag carries an unknown protocol byte is discarded, and a saturating drop counter records it. Frames without a tag leave unchanged and carry default sideband values.

Top module: `cputag_ingress`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, drop_count is 0 and the sideband shows the defaults given in R3.
- R2: A frame is tagged when it is at least 20 bytes long, bytes 12 and 13 (counting from 0) are 0x88 then 0x99, and byte 14 is 0x04. Its output is bytes 0 to 11 followed by byte 20 onward, with out_sof on the first beat and out_eof on the last. A frame of exactly 20 tagged bytes yields 12 output bytes.
- R3: Any other frame is forwarded byte for byte, including frames shorter than 20 bytes that begin a tag. Its sideband defaults are: all enables and flags 0, learning identifier 0, priority 0, allow 0, port mask all ones.
- R4: Tagged control fields are read as follows. Byte 16 bit 7 is the learning-identifier enable, bits 6:4 the 3-bit learning identifier, bit 3 the priority enable and bits 2:0 the priority. Byte 17 bit 7 is keep and bit 5 is learning-disable. Byte 15 and the other bits of byte 17 are ignored.
- R5: Byte 18 bit 7 is the allow flag and byte 19 bits 6:0 the port mask, with port p at bit p. Byte 18 bits 6:0 and byte 19 bit 7 are ignored. With allow set and a mask that is neither all zeros nor all ones, the mask is reported as received.
- R6: With allow set and a mask of all zeros or all ones, or with allow clear, the reported mask is all ones. The allow flag itself is reported as received.
- R7: The learning-identifier fields never narrow the reported port mask.
- R8: A tagged frame whose byte 14 is not 0x04 produces no output beat. drop_count then rises by one, saturating at its maximum.
- R9: Every beat of a frame carries the same sideband, from the first beat until the end-of-frame beat is accepted.
- R10: When input bytes arrive every cycle and out_ready stays high, the output beats of a frame appear in consecutive cycles, with no gap at the point where the header replay hands over to pass-through.
- R11: While out_ready is low, a presented beat holds its data and markers. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| sb_lid_en | output | 1 | Learning-identifier enable |
| sb_lid | output | 3 | Learning identifier |
| sb_pri_en | output | 1 | Priority enable |
| sb_pri | output | 3 | Priority |
| sb_keep | output | 1 | Keep flag |
| sb_learn_dis | output | 1 | Learning-disable flag |
| sb_allow | output | 1 | Allow flag as received |
| sb_port_mask | output | NPORT | Effective egress port mask |
| drop_count | output | ERR_W | Saturating count of discarded frames |

## Verification
Two events can fall on the same clock edge. One is the hand-over from replaying the last buffered header byte to passing live input. The other is a downstream stall. Either can hit byte 11 of a tagged frame or byte 19 of an untagged one.

The bench drives a pseudo-random out_ready pattern over frames of many payload lengths, so stalls land on both sides of that seam. The scoreboard then judges the exact byte order, markers and sideband of every accepted beat. In a separate run with out_ready held high, the bench confirms that the same seam adds no idle cycle.

// File: rtl/cputag_pkg.sv
package cputag_pkg;

  localparam int MAC_BYTES = 12;
  localparam int TAG_BYTES = 8;
  localparam int HDR_BYTES = MAC_BYTES + TAG_BYTES;

  localparam int OFS_TYPE  = MAC_BYTES;
  localparam int OFS_PROTO = MAC_BYTES + 2;
  localparam int OFS_CTRL  = MAC_BYTES + 4;
  localparam int OFS_ALLOW = MAC_BYTES + 6;

  localparam logic [7:0] TAG_TYPE_HI = 8'h88;
  localparam logic [7:0] TAG_TYPE_LO = 8'h99;
  localparam logic [7:0] TAG_PROTO   = 8'h04;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_DRAIN,
    ST_PASS,
    ST_DISCARD
  } pstate_e;

  typedef struct packed {
    logic       lid_en;
    logic [2:0] lid;
    logic       pri_en;
    logic [2:0] pri;
    logic       keep;
    logic       learn_dis;
    logic       allow;
  } ctl_t;

endpackage

// File: rtl/cputag_hdr_buf.sv
module cputag_hdr_buf #(
  parameter int DEPTH = 20,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_sof,
  input  logic          push_eof,
  input  logic [7:0]    push_data,
  output logic [CW-1:0] fill,
  output logic          ended,
  output logic          slot_last,
  output logic [7:0]    bytes_o [DEPTH]
);

  logic [CW-1:0] wr_idx;
  logic [CW-1:0] fill_d;
  logic          ended_d;

  assign wr_idx    = push_sof ? '0 : fill;
  assign slot_last = (wr_idx == CW'(DEPTH - 1));

  always_comb begin
    fill_d  = fill;
    ended_d = ended;
    if (push) begin
      fill_d  = wr_idx + CW'(1);
      ended_d = push_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill  <= '0;
      ended <= 1'b0;
    end else begin
      fill  <= fill_d;
      ended <= ended_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] ent_q;
    logic       ent_we;
    assign ent_we = push && (wr_idx == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_we) begin
        ent_q <= push_data;
      end
    end
    assign bytes_o[g] = ent_q;
  end

  // R3: the fill level never runs past the header depth
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

// File: rtl/cputag_decode.sv
module cputag_decode
  import cputag_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int DEPTH = HDR_BYTES,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [7:0]       hb [DEPTH],
  input  logic [CW-1:0]    fill,
  output logic             take,
  output logic             drop,
  output ctl_t             ctl,
  output logic [NPORT-1:0] mask
);

  logic             hit;
  logic             proto_ok;
  logic [NPORT-1:0] raw_mask;
  logic             narrow;
  ctl_t             ctl_raw;

  assign hit = (fill == CW'(DEPTH)) &&
               (hb[OFS_TYPE] == TAG_TYPE_HI) &&
               (hb[OFS_TYPE + 1] == TAG_TYPE_LO);
  assign proto_ok = (hb[OFS_PROTO] == TAG_PROTO);
  assign take = hit && proto_ok;
  assign drop = hit && !proto_ok;

  for (genvar p = 0; p < NPORT; p++) begin : g_mbit
    assign raw_mask[p] = hb[OFS_ALLOW + 1 - p / 8][p % 8];
  end

  always_comb begin
    ctl_raw.lid_en    = hb[OFS_CTRL][7];
    ctl_raw.lid       = hb[OFS_CTRL][6:4];
    ctl_raw.pri_en    = hb[OFS_CTRL][3];
    ctl_raw.pri       = hb[OFS_CTRL][2:0];
    ctl_raw.keep      = hb[OFS_CTRL + 1][7];
    ctl_raw.learn_dis = hb[OFS_CTRL + 1][5];
    ctl_raw.allow     = hb[OFS_ALLOW][7];
  end

  assign narrow = ctl_raw.allow && (raw_mask != '0) && (raw_mask != '1);
  assign ctl    = take ? ctl_raw : '0;
  assign mask   = (take && narrow) ? raw_mask : '1;

endmodule

// File: rtl/cputag_err_cnt.sv
module cputag_err_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (inc && (count != '1)) begin
      count_d = count + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_d;
    end
  end

  // R8: the drop count only ever steps up by one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + W'(1)));

  // R8: a saturated count stays saturated
  assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == '1) |-> (count == '1));

endmodule

// File: rtl/cputag_ingress.sv
module cputag_ingress
  import cputag_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             sb_lid_en,
  output logic [2:0]       sb_lid,
  output logic             sb_pri_en,
  output logic [2:0]       sb_pri,
  output logic             sb_keep,
  output logic             sb_learn_dis,
  output logic             sb_allow,
  output logic [NPORT-1:0] sb_port_mask,
  output logic [ERR_W-1:0] drop_count
);

  localparam int DEPTH = HDR_BYTES;
  localparam int CW    = $clog2(DEPTH + 1);

  pstate_e          state_q, state_d;
  logic [CW-1:0]    rd_q, rd_d;
  logic             push;
  logic [CW-1:0]    fill;
  logic             ended;
  logic             slot_last;
  logic [7:0]       hb [DEPTH];
  logic             take;
  logic             drop;
  ctl_t             ctl;
  logic [NPORT-1:0] mask;
  logic [CW-1:0]    last_idx;
  logic             drain_fire;
  logic             drain_end;
  logic             err_inc;
  logic             pass_fire;

  assign push = (state_q == ST_COLLECT) && in_valid;

  cputag_hdr_buf #(.DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_sof  (in_sof),
    .push_eof  (in_eof),
    .push_data (in_data),
    .fill      (fill),
    .ended     (ended),
    .slot_last (slot_last),
    .bytes_o   (hb)
  );

  cputag_decode #(.NPORT(NPORT), .DEPTH(DEPTH)) u_dec (
    .hb   (hb),
    .fill (fill),
    .take (take),
    .drop (drop),
    .ctl  (ctl),
    .mask (mask)
  );

  cputag_err_cnt #(.W(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_inc),
    .count (drop_count)
  );

  assign last_idx   = take ? CW'(MAC_BYTES - 1) : fill - CW'(1);
  assign drain_fire = (state_q == ST_DRAIN) && !drop && out_ready;
  assign drain_end  = drain_fire && (rd_q == last_idx);
  assign err_inc    = (state_q == ST_DRAIN) && drop;
  assign pass_fire  = (state_q == ST_PASS) && in_valid && out_ready;

  // sideband: decoded straight from the held header, stable for the frame
  assign sb_lid_en    = ctl.lid_en;
  assign sb_lid       = ctl.lid;
  assign sb_pri_en    = ctl.pri_en;
  assign sb_pri       = ctl.pri;
  assign sb_keep      = ctl.keep;
  assign sb_learn_dis = ctl.learn_dis;
  assign sb_allow     = ctl.allow;
  assign sb_port_mask = mask;

  // stream outputs
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    unique case (state_q)
      ST_COLLECT: begin
        in_ready = 1'b1;
      end
      ST_DRAIN: begin
        out_valid = !drop;
        out_data  = hb[rd_q];
        out_sof   = (rd_q == '0);
        out_eof   = ended && (rd_q == last_idx);
      end
      ST_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_eof   = in_eof;
      end
      ST_DISCARD: begin
        in_ready = 1'b1;
      end
      default: begin
        in_ready = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    unique case (state_q)
      ST_COLLECT: begin
        if (push && (in_eof || slot_last)) begin
          state_d = ST_DRAIN;
          rd_d    = '0;
        end
      end
      ST_DRAIN: begin
        if (drop) begin
          state_d = ended ? ST_COLLECT : ST_DISCARD;
          rd_d    = '0;
        end else if (drain_end) begin
          state_d = ended ? ST_COLLECT : ST_PASS;
          rd_d    = '0;
        end else if (drain_fire) begin
          rd_d = rd_q + CW'(1);
        end
      end
      ST_PASS: begin
        if (pass_fire && in_eof) begin
          state_d = ST_COLLECT;
        end
      end
      ST_DISCARD: begin
        if (in_valid && in_eof) begin
          state_d = ST_COLLECT;
        end
      end
      default: begin
        state_d = ST_COLLECT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
    end
  end

  // R9: sideband unchanged until the end-of-frame beat is taken
  assert_sb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_eof)) |=>
      $stable({sb_lid_en, sb_lid, sb_pri_en, sb_pri, sb_keep,
               sb_learn_dis, sb_allow, sb_port_mask}));

  // R11: a stalled beat keeps its contents
  assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  // R6: the reported mask is never empty
  assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sb_port_mask != '0);

  // R2: a frame that ends inside the header returns to collection
  assert_short_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DRAIN) && out_valid && out_ready && out_eof) |=>
      (state_q == ST_COLLECT));

  // R8: a discarded frame shows no output beat
  assert_discard_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_count != '0) |-> !out_valid);

endmodule

// File: tb/cputag_ingress_bench.sv
`timescale 1ns/1ps
module cputag_ingress_bench;

  localparam int NPORT = 7;
  localparam int ERR_W = 3;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [7:0]       in_data;
  logic             in_sof;
  logic             in_eof;
  logic             out_valid;
  logic             out_ready;
  logic [7:0]       out_data;
  logic             out_sof;
  logic             out_eof;
  logic             sb_lid_en;
  logic [2:0]       sb_lid;
  logic             sb_pri_en;
  logic [2:0]       sb_pri;
  logic             sb_keep;
  logic             sb_learn_dis;
  logic             sb_allow;
  logic [NPORT-1:0] sb_port_mask;
  logic [ERR_W-1:0] drop_count;

  always #2 clk = ~clk;

  cputag_ingress #(.NPORT(NPORT), .ERR_W(ERR_W)) u_cputag_ingress (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof),
    .sb_lid_en(sb_lid_en), .sb_lid(sb_lid), .sb_pri_en(sb_pri_en),
    .sb_pri(sb_pri), .sb_keep(sb_keep), .sb_learn_dis(sb_learn_dis),
    .sb_allow(sb_allow), .sb_port_mask(sb_port_mask),
    .drop_count(drop_count)
  );

  typedef struct packed {
    logic [7:0]  d;
    logic        sof;
    logic        eof;
    logic        gchk;
    logic [17:0] sb;
  } exp_t;

  exp_t        exp_q[$];
  string       nm_q[$];
  logic [7:0]  fr[$];
  int          checks = 0;
  int          errors = 0;
  int          exp_err = 0;
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          gaps = 0;
  bit          infr = 1'b0;
  exp_t        e;
  string       nm;
  logic [17:0] sbv;

  function automatic logic [17:0] mk_sb(input logic le, input logic [2:0] l,
      input logic pe, input logic [2:0] p, input logic k, input logic ld,
      input logic al, input logic [6:0] m);
    return {le, l, pe, p, k, ld, al, m};
  endfunction

  localparam logic [17:0] DEF_SB = {11'b0, 7'h7F};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic build_tagged(input int pay, input logic [7:0] proto,
                              input logic [15:0] ctrl, input logic [15:0] am);
    fr.delete();
    for (int i = 0; i < 12; i++) fr.push_back(8'(8'h10 + i * 5));
    fr.push_back(8'h88); fr.push_back(8'h99);
    fr.push_back(proto); fr.push_back(8'h3C);
    fr.push_back(ctrl[15:8]); fr.push_back(ctrl[7:0]);
    fr.push_back(am[15:8]); fr.push_back(am[7:0]);
    for (int i = 0; i < pay; i++) fr.push_back(8'(i * 13 + 1));
  endtask

  task automatic build_plain(input int n, input logic [15:0] et);
    fr.delete();
    for (int i = 0; i < n; i++) begin
      if (i < 12)       fr.push_back(8'(8'h40 + i * 3));
      else if (i == 12) fr.push_back(et[15:8]);
      else if (i == 13) fr.push_back(et[7:0]);
      else              fr.push_back(8'(i * 11 + 7));
    end
  endtask

  task automatic expect_frame(input logic [17:0] sb, input string req, input bit strip);
    int nout = strip ? fr.size() - 8 : fr.size();
    int k = 0;
    exp_t x;
    for (int i = 0; i < fr.size(); i++) begin
      if (strip && i >= 12 && i < 20) continue;
      x.d = fr[i]; x.sof = (k == 0); x.eof = (k == nout - 1);
      x.gchk = (rdy_mode == 0); x.sb = sb;
      exp_q.push_back(x); nm_q.push_back(req);
      k++;
    end
  endtask

  task automatic send_frame();
    bit acc;
    for (int i = 0; i < fr.size(); i++) begin
      in_valid = 1'b1; in_data = fr[i];
      in_sof = (i == 0); in_eof = (i == fr.size() - 1);
      forever begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
        if (acc) break;
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic tx_tag(input int pay, input logic [7:0] proto, input logic [15:0] ctrl,
                        input logic [15:0] am, input logic [17:0] sb, input string req);
    build_tagged(pay, proto, ctrl, am);
    if (proto == 8'h04) expect_frame(sb, req, 1'b1);
    else exp_err++;
    send_frame();
  endtask

  task automatic tx_plain(input int n, input logic [15:0] et, input string req);
    build_plain(n, et);
    expect_frame(DEF_SB, req, 1'b0);
    send_frame();
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // downstream ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        sbv = {sb_lid_en, sb_lid, sb_pri_en, sb_pri, sb_keep, sb_learn_dis,
               sb_allow, sb_port_mask};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected beat", {22'b0, out_data, out_sof, out_eof}, 0);
        end else begin
          e = exp_q.pop_front(); nm = nm_q.pop_front();
          chk({out_data, out_sof, out_eof} == {e.d, e.sof, e.eof}, nm, "beat R11",
              {22'b0, out_data, out_sof, out_eof}, {22'b0, e.d, e.sof, e.eof});
          chk(sbv == e.sb, nm, "sideband R9", {14'b0, sbv}, {14'b0, e.sb});
          if (out_sof) begin infr = 1'b1; gaps = 0; end
          if (out_eof) begin
            if (e.gchk) chk(gaps == 0, "R10", "idle cycles in frame", gaps, 0);
            infr = 1'b0;
          end
        end
      end else if (infr) begin
        gaps++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(drop_count == 0, "R1", "drop_count", drop_count, 0);
    chk({sb_lid_en, sb_lid, sb_pri_en, sb_pri, sb_keep, sb_learn_dis, sb_allow,
         sb_port_mask} == DEF_SB, "R1", "sideband", 0, DEF_SB);
    @(posedge clk); #1;

    // continuous mode: gap checks active
    tx_plain(30, 16'h0800, "R3");
    tx_tag(10, 8'h04, 16'hDEFF, 16'hFF95, mk_sb(1, 5, 1, 6, 1, 1, 1, 7'h15), "R4");
    tx_tag(6, 8'h04, 16'h2540, 16'h8040, mk_sb(0, 2, 0, 5, 0, 0, 1, 7'h40), "R5");
    tx_tag(5, 8'h04, 16'hB000, 16'h8000, mk_sb(1, 3, 0, 0, 0, 0, 1, 7'h7F), "R6");
    tx_tag(5, 8'h04, 16'h0000, 16'h807F, mk_sb(0, 0, 0, 0, 0, 0, 1, 7'h7F), "R6");
    tx_tag(5, 8'h04, 16'h0000, 16'h0005, mk_sb(0, 0, 0, 0, 0, 0, 0, 7'h7F), "R6");
    tx_tag(4, 8'h04, 16'hF000, 16'h8005, mk_sb(1, 7, 0, 0, 0, 0, 1, 7'h05), "R7");
    tx_tag(0, 8'h04, 16'h0820, 16'h8003, mk_sb(0, 0, 1, 0, 0, 1, 1, 7'h03), "R2");
    tx_tag(1, 8'h04, 16'h0000, 16'h8001, mk_sb(0, 0, 0, 0, 0, 0, 1, 7'h01), "R2");
    tx_tag(8, 8'h05, 16'hDEFF, 16'h8015, DEF_SB, "R8");
    tx_tag(7, 8'h04, 16'h9100, 16'h8020, mk_sb(1, 1, 0, 1, 0, 0, 1, 7'h20), "R8");
    tx_tag(0, 8'hFF, 16'h0000, 16'h0000, DEF_SB, "R8");
    build_plain(15, 16'h8899); fr[14] = 8'h04;
    expect_frame(DEF_SB, "R3", 1'b0); send_frame();
    tx_plain(1, 16'h0000, "R3");
    tx_plain(20, 16'h86DD, "R3");
    tx_plain(21, 16'h8100, "R3");
    wait_idle();
    chk(drop_count == ERR_W'(exp_err), "R8", "drop_count after drops", drop_count, exp_err);

    // backpressure mode
    rdy_mode = 1;
    for (int n = 0; n < 6; n++) begin
      tx_tag(n * 3, 8'h04, 16'hA5A0, 16'h800C, mk_sb(1, 2, 0, 5, 1, 1, 1, 7'h0C), "R11");
      tx_plain(14 + n * 3, 16'h0806, "R11");
    end
    tx_tag(3, 8'h01, 16'h0000, 16'h0000, DEF_SB, "R8");
    tx_tag(2, 8'h04, 16'h0000, 16'h0000, mk_sb(0, 0, 0, 0, 0, 0, 0, 7'h7F), "R11");
    wait_idle();
    rdy_mode = 0;

    // saturate the drop counter
    for (int n = 0; n < 8; n++) tx_tag(n, 8'h07, 16'h0000, 16'h8001, DEF_SB, "R8");
    tx_plain(16, 16'h0800, "R3");
    wait_idle();
    chk(drop_count == ERR_W'(ERR_MAX), "R8", "drop_count saturation", drop_count, ERR_MAX);
    chk(exp_q.size() == 0, "R2", "pending expected beats", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule